// File: doc/BRIEF.md
# Eight-Channel Edge-Aligned PWM Timer

This block drives eight pulse-width-modulated outputs from one shared 16-bit up-counter. Software programs it through a small 32-bit register window: it picks which of three tick sources advances the counter, sets a power-of-two prescale, and sets the modulo limit and the reload value. Together these fix one common period for all channels. Each channel has its own compare value and mode bits. A compare value below the modulo gives a duty fraction of compare/(modulo+1).

Each channel output goes through a per-channel polarity inversion and then a per-channel mask. A masked channel drives its programmed idle level instead of its waveform. After reset every channel is masked and every idle level is low, so all outputs are quiet until software releases them.

Top module: `mcpwm_timer`

## Requirements
- R1: After reset every register reads 0 except the output mask at 0x60, which reads 0xFF, the live count reads 0 and every output is 0.
- R2: Registers read back what was written at these word offsets: control 0x00 (prescale exponent in bits [2:0], clock select in bits [4:3]), modulo 0x08 (bits [15:0]), reload value 0x4C (bits [15:0]), idle level 0x5C (bit n per channel), mask 0x60 (bit n), polarity 0x70 (bit n). Channel n has a mode register at 0x0C+8n, which keeps only bits [5:2], and a compare register at 0x10+8n (bits [15:0]).
- R3: A read from any other offset, including unaligned ones, returns 0. A write there changes no register.
- R4: Clock select 1 advances the counter on the system tick, 2 on the fixed-rate tick and 3 on the external tick. With select 0 the counter holds its value.
- R5: With prescale exponent P, the counter advances once every 2^P selected ticks, for P from 0 to 7.
- R6: The live count at 0x04 counts up by one per step. On a step taken at or above the modulo, it loads the reload value instead.
- R7: With mode bits 5 and 3 set (high-true), the raw output is 1 while count < compare and 0 otherwise. Compare 0 therefore gives a constant 0, and compare above the modulo gives a constant 1.
- R8: With mode bit 5 set, bit 3 clear and bit 2 set (low-true), the raw output is the complement of the high-true one. With bit 5 clear, or with both bit 3 and bit 2 clear, the raw output is 0. Bit 4 has no effect.
- R9: A set polarity bit inverts that channel's raw output.
- R10: A set mask bit forces that channel's output to its idle-level bit, whatever the counter, mode or polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sys_tick | input | 1 | System tick enable |
| fix_tick | input | 1 | Fixed-rate tick enable |
| ext_tick | input | 1 | External tick enable |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, taken at the clock edge when bus_sel is high |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 8 | Channel outputs, bit n is channel n |

## Verification
The outputs are combinational from the live count and the registers, so a wrong count shows on pwm_out and at offset 0x04 in the same cycle it is stored. A wrong prescale or tick selection shifts the number of counter steps within a few tick periods. The bench therefore measures step counts and high-time over windows that are whole multiples of the expected period, which makes each result exact and free of phase effects. A corrupted mask, polarity or mode bit changes a whole window's high-time, so a single window exposes it.

// File: rtl/mcpwm_pkg.sv
// Package: register offsets and clock-select encoding shared by the timer.
// Assumes byte addressing with 32-bit word-aligned registers.
package mcpwm_pkg;

    typedef enum logic [1:0] {
        CK_OFF = 2'd0,
        CK_SYS = 2'd1,
        CK_FIX = 2'd2,
        CK_EXT = 2'd3
    } clk_sel_e;

    localparam int OFF_CTRL    = 'h00;
    localparam int OFF_COUNT   = 'h04;
    localparam int OFF_MOD     = 'h08;
    localparam int OFF_CH_BASE = 'h0C;
    localparam int CH_STRIDE   = 8;
    localparam int CH_CV_DELTA = 4;
    localparam int OFF_RELOAD  = 'h4C;
    localparam int OFF_IDLE    = 'h5C;
    localparam int OFF_MASK    = 'h60;
    localparam int OFF_POL     = 'h70;

endpackage

// File: rtl/mcpwm_regs.sv
// Register file: holds the programmable state and serves reads.
// Assumes NUM_CH <= 8 so the channel window ends below the reload register.
module mcpwm_regs
    import mcpwm_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_live,
    output logic [PS_W-1:0]   ps,
    output clk_sel_e          clksel,
    output logic [CNT_W-1:0]  mod_val,
    output logic [CNT_W-1:0]  reload_val,
    output logic [NUM_CH-1:0] idle_lvl,
    output logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] pol,
    output logic [3:0]        ch_mode [NUM_CH],
    output logic [CNT_W-1:0]  ch_cmp  [NUM_CH]
);
    localparam logic [NUM_CH-1:0] MASK_RST = '1;

    logic wr_en;
    logic unused_wdata;

    assign wr_en        = bus_sel && bus_wr;
    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

    // Purpose: capture register writes; reset clears all but the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps         <= '0;
            clksel     <= CK_OFF;
            mod_val    <= '0;
            reload_val <= '0;
            idle_lvl   <= '0;
            mask       <= MASK_RST;
            pol        <= '0;
            for (int i = 0; i < NUM_CH; i++) begin
                ch_mode[i] <= '0;
                ch_cmp[i]  <= '0;
            end
        end else if (wr_en) begin
            if (bus_addr == ADDR_W'(OFF_CTRL)) begin
                ps     <= bus_wdata[PS_W-1:0];
                clksel <= clk_sel_e'(bus_wdata[PS_W+1:PS_W]);
            end
            if (bus_addr == ADDR_W'(OFF_MOD))    mod_val    <= bus_wdata[CNT_W-1:0];
            if (bus_addr == ADDR_W'(OFF_RELOAD)) reload_val <= bus_wdata[CNT_W-1:0];
            if (bus_addr == ADDR_W'(OFF_IDLE))   idle_lvl   <= bus_wdata[NUM_CH-1:0];
            if (bus_addr == ADDR_W'(OFF_MASK))   mask       <= bus_wdata[NUM_CH-1:0];
            if (bus_addr == ADDR_W'(OFF_POL))    pol        <= bus_wdata[NUM_CH-1:0];
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ADDR_W'(OFF_CH_BASE + CH_STRIDE*i))
                    ch_mode[i] <= bus_wdata[5:2];
                if (bus_addr == ADDR_W'(OFF_CH_BASE + CH_STRIDE*i + CH_CV_DELTA))
                    ch_cmp[i] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    // Purpose: decode the read offset; anything unmapped reads as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CTRL)) begin
            bus_rdata[PS_W-1:0]      = ps;
            bus_rdata[PS_W+1:PS_W]   = clksel;
        end
        if (bus_addr == ADDR_W'(OFF_COUNT))  bus_rdata[CNT_W-1:0]  = cnt_live;
        if (bus_addr == ADDR_W'(OFF_MOD))    bus_rdata[CNT_W-1:0]  = mod_val;
        if (bus_addr == ADDR_W'(OFF_RELOAD)) bus_rdata[CNT_W-1:0]  = reload_val;
        if (bus_addr == ADDR_W'(OFF_IDLE))   bus_rdata[NUM_CH-1:0] = idle_lvl;
        if (bus_addr == ADDR_W'(OFF_MASK))   bus_rdata[NUM_CH-1:0] = mask;
        if (bus_addr == ADDR_W'(OFF_POL))    bus_rdata[NUM_CH-1:0] = pol;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(OFF_CH_BASE + CH_STRIDE*i))
                bus_rdata[5:2] = ch_mode[i];
            if (bus_addr == ADDR_W'(OFF_CH_BASE + CH_STRIDE*i + CH_CV_DELTA))
                bus_rdata[CNT_W-1:0] = ch_cmp[i];
        end
    end

endmodule

// File: rtl/mcpwm_tick.sv
// Tick selector and prescaler: emits one step per 2^ps selected ticks.
// Assumes tick inputs are single-cycle enables in the clk domain.
module mcpwm_tick
    import mcpwm_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sys_tick,
    input  logic            fix_tick,
    input  logic            ext_tick,
    input  clk_sel_e        clksel,
    input  logic [PS_W-1:0] ps,
    output logic            step
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic             sel_tick;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;

    // Purpose: pick the tick source named by the clock select.
    always_comb begin
        case (clksel)
            CK_SYS:  sel_tick = sys_tick;
            CK_FIX:  sel_tick = fix_tick;
            CK_EXT:  sel_tick = ext_tick;
            default: sel_tick = 1'b0;
        endcase
    end

    assign div_lim = DIV_W'((32'd1 << ps) - 32'd1);
    assign step    = sel_tick && (div_q >= div_lim);

    // Purpose: count selected ticks, restarting after each emitted step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (sel_tick)
            div_q <= step ? '0 : div_q + 1'b1;
    end

endmodule

// File: rtl/mcpwm_counter.sv
// Shared period counter: increments per step, reloads at or past the modulo.
// Assumes step is a single-cycle enable.
module mcpwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] mod_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt
);
    // Purpose: advance or reload the counter on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= (cnt >= mod_val) ? reload_val : cnt + 1'b1;
    end

endmodule

// File: rtl/mcpwm_chan.sv
// One output channel: compare, mode select, polarity, then mask.
// Assumes mode holds written bits {5,3,2}; bit 4 is not passed in.
module mcpwm_chan #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             pwm_en,
    input  logic             high_true,
    input  logic             low_true,
    input  logic             pol,
    input  logic             mask,
    input  logic             idle_lvl,
    output logic             out
);
    logic below;
    logic raw;

    assign below = cnt < cmp;

    // Purpose: form the unmasked edge-aligned level from the mode bits.
    always_comb begin
        if (!pwm_en)        raw = 1'b0;
        else if (high_true) raw = below;
        else if (low_true)  raw = !below;
        else                raw = 1'b0;
    end

    assign out = mask ? idle_lvl : (raw ^ pol);

endmodule

// File: rtl/mcpwm_timer.sv
// Top: eight-channel edge-aligned PWM timer with shared counter.
// Assumes a single clock domain; the bus read path is combinational.
module mcpwm_timer
    import mcpwm_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_tick,
    input  logic              fix_tick,
    input  logic              ext_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [PS_W-1:0]   ps;
    clk_sel_e          clksel;
    logic [CNT_W-1:0]  mod_val;
    logic [CNT_W-1:0]  reload_val;
    logic [NUM_CH-1:0] idle_lvl;
    logic [NUM_CH-1:0] mask;
    logic [NUM_CH-1:0] pol;
    logic [3:0]        ch_mode [NUM_CH];
    logic [CNT_W-1:0]  ch_cmp  [NUM_CH];
    logic              step;
    logic [CNT_W-1:0]  cnt;
    logic [NUM_CH-1:0] unused_mode_b4;

    mcpwm_regs #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PS_W(PS_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_live(cnt), .ps(ps), .clksel(clksel),
        .mod_val(mod_val), .reload_val(reload_val),
        .idle_lvl(idle_lvl), .mask(mask), .pol(pol),
        .ch_mode(ch_mode), .ch_cmp(ch_cmp)
    );

    mcpwm_tick #(.PS_W(PS_W)) u_tick (
        .clk(clk), .rst_n(rst_n),
        .sys_tick(sys_tick), .fix_tick(fix_tick), .ext_tick(ext_tick),
        .clksel(clksel), .ps(ps), .step(step)
    );

    mcpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step),
        .mod_val(mod_val), .reload_val(reload_val), .cnt(cnt)
    );

    // Stored mode bits map as [3]=bit5, [2]=bit4, [1]=bit3, [0]=bit2.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign unused_mode_b4[g] = ch_mode[g][2];
        mcpwm_chan #(.CNT_W(CNT_W)) u_chan (
            .cnt(cnt), .cmp(ch_cmp[g]),
            .pwm_en(ch_mode[g][3]), .high_true(ch_mode[g][1]),
            .low_true(ch_mode[g][0]),
            .pol(pol[g]), .mask(mask[g]), .idle_lvl(idle_lvl[g]),
            .out(pwm_out[g])
        );
    end

endmodule

// File: rtl/mcpwm_checker.sv
// Checker: temporal properties of the counter, clock hold and mask.
// Assumes it is bound to mcpwm_timer and sees its internal nets.
module mcpwm_checker #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        clksel,
    input logic              step,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  mod_val,
    input logic [CNT_W-1:0]  reload_val,
    input logic [NUM_CH-1:0] mask,
    input logic [NUM_CH-1:0] idle_lvl,
    input logic [NUM_CH-1:0] pwm_out
);
    // R4: no clock selected means the counter keeps its value.
    a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (clksel == 2'd0) |=> $stable(cnt));

    // R6: a step below the modulo adds exactly one.
    a_r6_step_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt < mod_val) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R6: a step at or past the modulo loads the reload value.
    a_r6_wrap_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt >= mod_val) |=> (cnt == $past(reload_val)));

    // R6: without a step the counter does not move.
    a_r6_no_step_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_mask
        // R10: a masked channel shows its idle level.
        a_r10_mask_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
            mask[g] |-> (pwm_out[g] == idle_lvl[g]));
    end

endmodule

bind mcpwm_timer mcpwm_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clksel(clksel), .step(step), .cnt(cnt),
    .mod_val(mod_val), .reload_val(reload_val), .mask(mask),
    .idle_lvl(idle_lvl), .pwm_out(pwm_out)
);

// File: tb/mcpwm_timer_test.sv
`timescale 1ns/1ps
// Directed bench for mcpwm_timer: one task per scenario.
module mcpwm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_tick = 1'b1;
    logic        fix_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [7:0]  pwm_out;

    int n_total = 0;
    int n_bad   = 0;

    always #2 clk = ~clk;

    mcpwm_timer uut (
        .clk(clk), .rst_n(rst_n),
        .sys_tick(sys_tick), .fix_tick(fix_tick), .ext_tick(ext_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // Fixed tick every 3 cycles, external tick every 5 cycles.
    initial begin
        int f = 0;
        int e = 0;
        forever begin
            @(negedge clk);
            f = (f + 1) % 3;
            e = (e + 1) % 5;
            fix_tick = (f == 0);
            ext_tick = (e == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic high_time(input int ch, input int n, output int h);
        h = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out[ch]) h++;
        end
    endtask

    task automatic count_delta(input int win, output int d);
        logic [31:0] a;
        logic [31:0] b;
        repeat (20) @(negedge clk);
        rd(8'h04, a);
        repeat (win - 1) @(negedge clk);
        rd(8'h04, b);
        d = int'(16'(b[15:0] - a[15:0]));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h00, d); check(d == 0, "R1 ctrl", d, 0);
        rd(8'h60, d); check(d == 32'hFF, "R1 mask", d, 255);
        rd(8'h70, d); check(d == 0, "R1 pol", d, 0);
        rd(8'h10, d); check(d == 0, "R1 cmp0", d, 0);
        rd(8'h04, d); check(d == 0, "R1 count", d, 0);
        check(pwm_out == 8'h00, "R1 outputs", pwm_out, 0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        wr(8'h00, 32'hFFFF_FFE5); rd(8'h00, d); check(d == 32'h05, "R2 ctrl", d, 5);
        wr(8'h08, 32'h1234_ABCD); rd(8'h08, d); check(d == 32'hABCD, "R2 mod", d, 32'hABCD);
        wr(8'h4C, 32'h0000_0007); rd(8'h4C, d); check(d == 7, "R2 reload", d, 7);
        wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, d); check(d == 32'h3C, "R2 mode7", d, 32'h3C);
        wr(8'h48, 32'h0000_0123); rd(8'h48, d); check(d == 32'h123, "R2 cmp7", d, 32'h123);
        wr(8'h70, 32'h0000_00A5); rd(8'h70, d); check(d == 32'hA5, "R2 pol", d, 32'hA5);
        wr(8'h5C, 32'h0000_003C); rd(8'h5C, d); check(d == 32'h3C, "R2 idle", d, 32'h3C);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h09, 32'h0000_0001);
        wr(8'h90, 32'h0000_FFFF);
        rd(8'h50, d); check(d == 0, "R3 read 0x50", d, 0);
        rd(8'h09, d); check(d == 0, "R3 read unaligned", d, 0);
        rd(8'h08, d); check(d == 32'hABCD, "R3 mod untouched", d, 32'hABCD);
        rd(8'h00, d); check(d == 32'h05, "R3 ctrl untouched", d, 5);
        rd(8'h48, d); check(d == 32'h123, "R3 cmp7 untouched", d, 32'h123);
    endtask

    task automatic t_clock_src;
        int d;
        wr(8'h70, 0); wr(8'h5C, 0); wr(8'h4C, 0); wr(8'h08, 32'hFFFF);
        wr(8'h00, 32'h08); count_delta(60, d); check(d == 60, "R4 system tick", d, 60);
        wr(8'h00, 32'h10); count_delta(60, d); check(d == 20, "R4 fixed tick", d, 20);
        wr(8'h00, 32'h18); count_delta(60, d); check(d == 12, "R4 external tick", d, 12);
        wr(8'h00, 32'h00); count_delta(60, d); check(d == 0, "R4 no clock holds", d, 0);
        wr(8'h00, 32'h0A); count_delta(60, d); check(d == 15, "R5 prescale 4", d, 15);
        wr(8'h00, 32'h11); count_delta(60, d); check(d == 10, "R5 fixed prescale 2", d, 10);
    endtask

    task automatic setup_ch0(input logic [31:0] mode, input logic [31:0] cmp);
        wr(8'h08, 9); wr(8'h4C, 0); wr(8'h0C, mode); wr(8'h10, cmp);
        wr(8'h60, 32'hFE); wr(8'h00, 32'h08);
        repeat (30) @(negedge clk);
    endtask

    task automatic t_duty;
        int h;
        setup_ch0(32'h28, 3);  high_time(0, 120, h); check(h == 36, "R7 duty 3/10", h, 36);
        setup_ch0(32'h38, 3);  high_time(0, 120, h); check(h == 36, "R8 bit4 ignored", h, 36);
        setup_ch0(32'h28, 0);  high_time(0, 120, h); check(h == 0, "R7 compare zero", h, 0);
        setup_ch0(32'h28, 12); high_time(0, 120, h); check(h == 120, "R7 compare above mod", h, 120);
        setup_ch0(32'h28, 3);
        wr(8'h00, 32'h09); repeat (30) @(negedge clk);
        high_time(0, 120, h); check(h == 36, "R5 duty under prescale 2", h, 36);
        wr(8'h34, 32'h28); wr(8'h38, 7); wr(8'h60, 32'hDE);
        repeat (30) @(negedge clk);
        high_time(5, 120, h); check(h == 84, "R7 channel 5 duty 7/10", h, 84);
    endtask

    task automatic t_reload;
        int h;
        logic [31:0] d;
        setup_ch0(32'h28, 7);
        wr(8'h4C, 4); repeat (30) @(negedge clk);
        high_time(0, 120, h); check(h == 60, "R6 reload value 4", h, 60);
        for (int i = 0; i < 6; i++) begin
            rd(8'h04, d);
            check(d >= 4 && d <= 9, "R6 count range", d, 4);
        end
    endtask

    task automatic t_modes;
        int h;
        setup_ch0(32'h24, 3); high_time(0, 120, h); check(h == 84, "R8 low-true", h, 84);
        setup_ch0(32'h08, 3); high_time(0, 120, h); check(h == 0, "R8 bit5 clear", h, 0);
        setup_ch0(32'h20, 3); high_time(0, 120, h); check(h == 0, "R8 no level bits", h, 0);
    endtask

    task automatic t_polarity;
        int h;
        setup_ch0(32'h28, 3);
        wr(8'h70, 32'h01); repeat (5) @(negedge clk);
        high_time(0, 120, h); check(h == 84, "R9 inverted", h, 84);
        wr(8'h70, 32'h00);
    endtask

    task automatic t_mask;
        int h;
        setup_ch0(32'h28, 3);
        wr(8'h5C, 32'h01); wr(8'h60, 32'hFF); repeat (5) @(negedge clk);
        high_time(0, 120, h); check(h == 120, "R10 masked idle high", h, 120);
        wr(8'h5C, 32'h00); repeat (2) @(negedge clk);
        high_time(0, 120, h); check(h == 0, "R10 masked idle low", h, 0);
        wr(8'h70, 32'h01); repeat (2) @(negedge clk);
        high_time(0, 120, h); check(h == 0, "R10 mask beats polarity", h, 0);
    endtask

    initial begin
        #400000;
        n_total++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regmap;
        t_unmapped;
        t_clock_src;
        t_duty;
        t_reload;
        t_modes;
        t_polarity;
        t_mask;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule